// File: doc/BRIEF.md
# Serial Transmit Flow-Control Gate

This block sits between the character source of a serial transmitter and its shift register. In every cycle it tells the transmitter whether the character in the holding register may be moved into the shifter. The answer depends on three things: the in-band pause and resume characters seen on the receive side, the clear-to-send handshake, and whether the channel is enabled. The block also drives the request-to-send pin from the state of the transmit queue.

Software programs two characters, one that halts transmission and one that resumes it. When in-band control is on and the halt character arrives, transmission stops. It stops only after the character being shifted has finished and after the character already waiting in the holding register has also gone out. An option lets any received character resume transmission instead of the resume character alone. The modem handshake pins are active-low. The clear-to-send pin passes through a configurable synchronizer before it is used.

Top module: `txfc_gate`

## Requirements
- R1: After reset, rts_n is 1 and no halt is in effect, so tx_permit equals the result of the channel, shifter and clear-to-send terms alone.
- R2: With inband_en set and transmission running, a cycle with rx_valid=1 and rx_data equal to xoff_char halts transmission from the next cycle on. tx_permit stays 0 once no drain credit is left.
- R3: If hold_full=1 and shift_load=0 in the cycle the halt character arrives, exactly one further load of the holding register is permitted. tx_permit then stays 0 after that load.
- R4: While halted with implied_xon=0, received characters other than xon_char leave the halt in place. A received xon_char ends the halt from the next cycle.
- R5: While halted with implied_xon=1, any received character, the halt character included, ends the halt from the next cycle.
- R6: While inband_en=0, received characters have no effect, and any halt or drain credit is cleared on the next cycle.
- R7: If xon_char equals xoff_char, a matching character halts a running transmitter and resumes a halted one.
- R8: tx_permit is 0 in every cycle in which shift_busy=1, so a character being shifted is never cut short.
- R9: tx_permit is 0 whenever chan_en=0.
- R10: With auto_cts=1, tx_permit requires cts_n to have been low for CTS_SYNC clock edges. If auto_rts=1 as well, it also requires rts_n to be already low.
- R11: rts_n is registered. It goes low one cycle after a cycle with auto_rts=1, chan_en=1 and any of q_nonempty, hold_full or shift_busy set. In every other case it is high one cycle later.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable |
| inband_en | input | 1 | Automatic in-band pause/resume control enable |
| implied_xon | input | 1 | Any received character resumes transmission |
| auto_rts | input | 1 | Drive rts_n from the queue state |
| auto_cts | input | 1 | Gate transmission on cts_n |
| xon_char | input | CHAR_W | Resume character |
| xoff_char | input | CHAR_W | Halt character |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | CHAR_W | Received character |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| q_nonempty | input | 1 | Transmit queue holds characters |
| hold_full | input | 1 | Holding register occupied |
| shift_busy | input | 1 | Shifter is sending a character |
| shift_load | input | 1 | Shifter takes the holding character this cycle |
| tx_permit | output | 1 | Shifter may load the next character |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bench targets the drain credit. A halt arriving while the holding register is full must allow exactly one more load, so a design that drops the credit would lose that character, and one that never clears it would keep sending after the halt. It also covers equal resume and halt characters, where a wrong design would halt forever or never halt, and the implied-resume option when the halt character itself is received. The clear-to-send path is checked for its synchronizer latency and for waiting on RTS, where an off-by-one would permit a load early or late. Random traffic also drives the pause and resume characters while the shifter is busy, which catches a design that lets the permit through mid-character.

// File: rtl/txfc_pkg.sv
package txfc_pkg;

    // In-band pause state: halted flag plus one pending drain credit
    typedef struct packed {
        logic stopped;
        logic drain;
    } inband_st_t;

    // Modem handshake state
    typedef struct packed {
        logic rts;
    } modem_st_t;

endpackage

// File: rtl/txfc_match.sv
module txfc_match #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    output logic              hit_xon,
    output logic              hit_xoff
);
    always_comb begin
        hit_xon  = (rx_data == xon_char);
        hit_xoff = (rx_data == xoff_char);
    end
endmodule

// File: rtl/txfc_sync.sv
module txfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_d, pipe_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb pipe_d[i] = d;
        end else begin : g_rest
            always_comb pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[LAST];
endmodule

// File: rtl/txfc_inband.sv
module txfc_inband
    import txfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inband_en,
    input  logic implied_xon,
    input  logic rx_valid,
    input  logic hit_xon,
    input  logic hit_xoff,
    input  logic hold_full,
    input  logic shift_load,
    output logic stopped,
    output logic drain
);
    inband_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a pending credit is spent when the shifter takes the holding char
        if (shift_load) st_d.drain = 1'b0;
        if (!inband_en) begin
            st_d = '0;
        end else if (rx_valid) begin
            if (!st_q.stopped) begin
                if (hit_xoff) begin
                    st_d.stopped = 1'b1;
                    // char waiting in the holding register still goes out
                    st_d.drain   = hold_full & ~shift_load;
                end
            end else if (implied_xon || hit_xon) begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stopped = st_q.stopped;
    assign drain   = st_q.drain;
endmodule

// File: rtl/txfc_gate.sv
module txfc_gate
    import txfc_pkg::*;
#(
    parameter int CHAR_W   = 8,
    parameter int CTS_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              inband_en,
    input  logic              implied_xon,
    input  logic              auto_rts,
    input  logic              auto_cts,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              cts_n,
    input  logic              q_nonempty,
    input  logic              hold_full,
    input  logic              shift_busy,
    input  logic              shift_load,
    output logic              tx_permit,
    output logic              rts_n
);
    logic hit_xon, hit_xoff;
    logic stopped, drain;
    logic cts_on;
    logic cts_ok, flow_ok;

    modem_st_t st_d, st_q;

    txfc_match #(.CHAR_W(CHAR_W)) u_match (
        .rx_data  (rx_data),
        .xon_char (xon_char),
        .xoff_char(xoff_char),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff)
    );

    txfc_inband u_inband (
        .clk        (clk),
        .rst_n      (rst_n),
        .inband_en  (inband_en),
        .implied_xon(implied_xon),
        .rx_valid   (rx_valid),
        .hit_xon    (hit_xon),
        .hit_xoff   (hit_xoff),
        .hold_full  (hold_full),
        .shift_load (shift_load),
        .stopped    (stopped),
        .drain      (drain)
    );

    // pin is active low; internal sense is active high
    txfc_sync #(.STAGES(CTS_SYNC)) u_cts_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (~cts_n),
        .q    (cts_on)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rts = auto_rts & chan_en & (q_nonempty | hold_full | shift_busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cts_ok    = ~auto_cts | (cts_on & (~auto_rts | st_q.rts));
        flow_ok   = ~stopped | drain;
        // only at a character boundary: never while the shifter is busy
        tx_permit = chan_en & ~shift_busy & cts_ok & flow_ok;
        rts_n     = ~st_q.rts;
    end
endmodule

// File: rtl/txfc_gate_chk.sv
module txfc_gate_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_en,
    input logic              inband_en,
    input logic              implied_xon,
    input logic              auto_rts,
    input logic              auto_cts,
    input logic [CHAR_W-1:0] xon_char,
    input logic [CHAR_W-1:0] xoff_char,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              q_nonempty,
    input logic              hold_full,
    input logic              shift_busy,
    input logic              tx_permit,
    input logic              rts_n
);
    a_r8_no_permit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        shift_busy |-> !tx_permit);

    a_r9_no_permit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !tx_permit);

    a_r2_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (inband_en && !implied_xon && rx_valid && rx_data == xoff_char &&
         xon_char != xoff_char && !hold_full) |=> !tx_permit);

    a_r5_any_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (inband_en && implied_xon && rx_valid && rx_data != xoff_char) |=>
        (!(chan_en && !auto_cts && !shift_busy) || tx_permit));

    a_r6_inband_off: assert property (@(posedge clk) disable iff (!rst_n)
        !inband_en |=> (!(chan_en && !auto_cts && !shift_busy) || tx_permit));

    a_r11_rts_on: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && chan_en && (q_nonempty || hold_full || shift_busy)) |=> !rts_n);

    a_r11_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en || !auto_rts || (!q_nonempty && !hold_full && !shift_busy)) |=> rts_n);
endmodule

bind txfc_gate txfc_gate_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .inband_en  (inband_en),
    .implied_xon(implied_xon),
    .auto_rts   (auto_rts),
    .auto_cts   (auto_cts),
    .xon_char   (xon_char),
    .xoff_char  (xoff_char),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .q_nonempty (q_nonempty),
    .hold_full  (hold_full),
    .shift_busy (shift_busy),
    .tx_permit  (tx_permit),
    .rts_n      (rts_n)
);

// File: tb/sim_txfc_gate.sv
module sim_txfc_gate;
    localparam int W  = 8;
    localparam int NS = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic chan_en = 1'b0, inband_en = 1'b1, implied_xon = 1'b0;
    logic auto_rts = 1'b0, auto_cts = 1'b0;
    logic [W-1:0] xon_c = 8'h11, xoff_c = 8'h13, rx_data = '0;
    logic rx_valid = 1'b0, cts_n = 1'b1;
    logic q_nonempty = 1'b0, hold_full = 1'b0, shift_busy = 1'b0, shift_load = 1'b0;
    logic tx_permit, rts_n;

    int checks = 0, fails = 0;
    bit finished = 0;
    // reference model state
    bit m_stop = 0, m_drain = 0, m_rts = 0;
    bit [NS-1:0] m_cts = '0;
    // source and shifter model
    int q_cnt = 0, busy_cnt = 0;
    bit hf = 0, load_ok = 0, refill = 0;

    always #5 clk = ~clk;

    txfc_gate #(.CHAR_W(W), .CTS_SYNC(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .inband_en(inband_en),
        .implied_xon(implied_xon), .auto_rts(auto_rts), .auto_cts(auto_cts),
        .xon_char(xon_c), .xoff_char(xoff_c), .rx_valid(rx_valid), .rx_data(rx_data),
        .cts_n(cts_n), .q_nonempty(q_nonempty), .hold_full(hold_full),
        .shift_busy(shift_busy), .shift_load(shift_load),
        .tx_permit(tx_permit), .rts_n(rts_n)
    );

    function automatic bit f_cts_ok();
        return !auto_cts || (m_cts[NS-1] && (!auto_rts || m_rts));
    endfunction

    function automatic bit f_permit();
        return chan_en && !shift_busy && f_cts_ok() && (!m_stop || m_drain);
    endfunction

    function automatic string f_tag();
        if (shift_busy)                 return "R8";
        if (!chan_en)                   return "R9";
        if (!f_cts_ok())                return "R10";
        if (m_stop && m_drain)          return "R3";
        if (m_stop)                     return "R2";
        return "R6";
    endfunction

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic step(string tag);
        bit ep, n_stop, n_drain, n_rts;
        bit [NS-1:0] n_cts;
        string t;
        @(negedge clk);
        shift_busy = (busy_cnt != 0);
        hold_full  = hf;
        q_nonempty = (q_cnt > 0);
        ep = f_permit();
        shift_load = ep && hf && load_ok;
        #1;
        t = (tag == "") ? f_tag() : tag;
        chk(t, tx_permit, ep, "tx_permit");
        chk("R11", rts_n, !m_rts, "rts_n");
        n_stop  = m_stop;
        n_drain = m_drain && !shift_load;
        if (!inband_en) begin
            n_stop = 0; n_drain = 0;
        end else if (rx_valid) begin
            if (!m_stop) begin
                if (rx_data == xoff_c) begin
                    n_stop = 1; n_drain = hold_full && !shift_load;
                end
            end else if (implied_xon || rx_data == xon_c) begin
                n_stop = 0; n_drain = 0;
            end
        end
        n_rts = auto_rts && chan_en && (q_nonempty || hold_full || shift_busy);
        n_cts = {m_cts[NS-2:0], !cts_n};
        @(posedge clk);
        #1;
        m_stop = n_stop; m_drain = n_drain; m_rts = n_rts; m_cts = n_cts;
        if (shift_load) begin
            hf = 0;
            busy_cnt = 1 + int'($urandom % 4);
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        if (!hf && q_cnt > 0 && refill) begin
            hf = 1; q_cnt--;
        end
        rx_valid = 0;
        shift_load = 0;
    endtask

    task automatic rx(logic [W-1:0] c, string tag);
        rx_valid = 1; rx_data = c;
        step(tag);
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chan_en = 1;
        rst_n = 1;
        #1;
        chk("R1", rts_n, 1'b1, "rts_n after reset");
        chk("R1", tx_permit, 1'b1, "tx_permit after reset");
        step("R1");

        // R2: halt with empty holding register
        rx(xoff_c, "R2");
        step("R2");
        // R4: non-resume char keeps halt, resume char ends it
        rx(8'h41, "R4");
        rx(xoff_c, "R4");
        rx(xon_c, "R4");

        // R3: halt while holding register is full
        hf = 1;
        rx_valid = 1; rx_data = xoff_c;
        step("R3");
        step("R3");
        load_ok = 1;
        step("R3");
        load_ok = 0;
        hf = 1;
        for (int i = 0; i < 7; i++) step("R3");
        hf = 0;

        // R5: any char, even the halt char, resumes
        implied_xon = 1;
        rx(xoff_c, "R5");
        rx(8'h7E, "R5");
        implied_xon = 0;

        // R6: disabling in-band control clears halt and ignores chars
        rx(xoff_c, "R6");
        inband_en = 0;
        step("R6");
        rx(xoff_c, "R6");
        step("R6");
        inband_en = 1;

        // R7: identical resume and halt characters
        xon_c = 8'h5A; xoff_c = 8'h5A;
        rx(8'h5A, "R7");
        rx(8'h5A, "R7");
        xon_c = 8'h11; xoff_c = 8'h13;

        // R10: clear-to-send gating with synchronizer latency
        auto_cts = 1;
        for (int i = 0; i < 3; i++) step("R10");
        cts_n = 0;
        for (int i = 0; i < 4; i++) step("R10");
        auto_rts = 1;
        for (int i = 0; i < 2; i++) step("R10");
        q_cnt = 2;
        for (int i = 0; i < 3; i++) step("R10");
        auto_rts = 0; auto_cts = 0; q_cnt = 0;
        step("R11");

        // R9 and R8
        chan_en = 0;
        step("R9");
        chan_en = 1;
        busy_cnt = 3;
        step("R8");
        step("R8");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 64 == 0) inband_en   = ~inband_en;
            if ($urandom % 64 == 0) implied_xon = ~implied_xon;
            if ($urandom % 48 == 0) auto_rts    = ~auto_rts;
            if ($urandom % 48 == 0) auto_cts    = ~auto_cts;
            if ($urandom % 32 == 0) chan_en     = ~chan_en;
            if ($urandom % 16 == 0) cts_n       = ~cts_n;
            if ($urandom % 200 == 0) xoff_c     = (xoff_c == xon_c) ? 8'h13 : xon_c;
            if ($urandom % 5 == 0) q_cnt += int'($urandom % 3);
            load_ok = ($urandom % 4 != 0);
            refill  = ($urandom % 3 != 0);
            if ($urandom % 6 == 0) begin
                rx_valid = 1;
                case ($urandom % 3)
                    0: rx_data = xon_c;
                    1: rx_data = xoff_c;
                    default: rx_data = W'($urandom);
                endcase
            end
            step("");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule